// File: doc/BRIEF.md
# DMA Window Descriptor Builder

This block turns one request for a memory window into a descriptor held in a word-addressed instance memory. A request gives an object class, a byte offset, a byte size, an access mode, a target space, a base word address for the descriptor and a choice between a contiguous window and a page-listed window. After a one-cycle start pulse the block writes the descriptor one 32-bit word per write cycle through a simple write port. It then raises a one-cycle completion pulse that carries an error flag and the number of words it wrote.

A contiguous window always takes four words: two header words and one page-table entry written twice, where the second copy marks the end of the table. A page-listed window takes the two header words and then one entry per page the window covers. The block fetches each page's bus address through a read port into a page-address memory that has one cycle of read latency. Before it writes anything for a page-listed window, it checks that the pages it needs exist. When the target is the host aperture, the block adds an aperture base to the offset before it derives any field from the offset.

Top module: `dma_desc_builder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `wr_en` and `pg_rd_en` are low.
- R2: A `start` pulse taken while `busy` is low launches a build, and `busy` is high from the next cycle through the cycle of `done`. A `start` pulse while `busy` is high is ignored, and the build in progress keeps its original inputs.
- R3: Header word 0 is written at `desc_base`. Its fields are: bits 11:0 the class; bit 12 set; bit 13 set for a contiguous window and clear for a page-listed one; bits 15:14 the access mode (0 read/write, 1 read-only, 2 write-only); bits 17:16 the target; bits 19:18 zero; bits 31:20 the low 12 bits of the effective offset.
- R4: Header word 1, at `desc_base+1`, holds the window size minus one, taken modulo 2^32. A size of 0 therefore gives 0xFFFFFFFF.
- R5: A contiguous window writes exactly four words, at `desc_base` through `desc_base+3`. Words 2 and 3 both hold the effective offset with bits 11:0 cleared, with bit 1 set unless the access mode is 1 (read-only).
- R6: A page-listed window covers ceil(size / PAGE_BYTES) pages, starting at page index floor(effective offset / PAGE_BYTES). Entry i is written at `desc_base+2+i`. Its bits 31:12 are bits 31:12 of the page-address memory word at page index start+i, bits 11:2 and bit 0 are zero, and bit 1 is set unless the access mode is read-only.
- R7: For a page-listed window, if the start page index plus the page count is greater than `pages_avail`, the block writes nothing, and `done` comes with `err` high and a word count of 0. A sum equal to `pages_avail` is accepted.
- R8: When `target_sel` is 3 (host aperture), the effective offset is `win_offset + aperture_base` modulo 2^32. For any other target it is `win_offset`. Every offset-derived field uses the effective offset.
- R9: `done` is high for exactly one cycle. In that cycle `words_written` equals the number of write cycles in the build, and `busy` is low in the cycle after.
- R10: Each page-address read is issued with `pg_rd_en` one cycle before the entry write that uses it. The returned word is sampled in that write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| desc_base | input | ADDR_W | Word address of descriptor word 0 |
| obj_class | input | 12 | Object class field |
| win_offset | input | 32 | Window byte offset |
| win_size | input | 32 | Window byte size |
| access_mode | input | 2 | 0 read/write, 1 read-only, 2 write-only |
| target_sel | input | 2 | Target space; 3 selects the host aperture |
| sg_mode | input | 1 | 1 selects a page-listed window |
| aperture_base | input | 32 | Added to the offset for target 3 |
| pages_avail | input | PG_AW+1 | Number of pages present in page-address memory |
| pg_rd_en | output | 1 | Page-address memory read enable |
| pg_rd_addr | output | PG_AW | Page-address memory read index |
| pg_rd_data | input | 32 | Page bus address, valid one cycle after the read |
| wr_en | output | 1 | Instance memory write strobe |
| wr_addr | output | ADDR_W | Instance memory word address |
| wr_data | output | 32 | Instance memory write data |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Page range error, valid with done |
| words_written | output | WCNT_W | Words written, valid with done |

## Verification
The bench aims at the boundaries of the page range check. It tries a window that ends exactly on the last available page and one that ends one page past it. A design with an off-by-one in the comparison would either reject a legal window or write entries beyond the available pages. It also tries sizes of zero, exactly one page and one byte over a page, so that a wrong round-up shows as a missing entry or an extra one. A host-aperture case with an offset that wraps past 2^32 catches a design that derives fields from the raw offset. A start pulse during a build catches a design that relatches its inputs and corrupts the descriptor. Read-only access checks that the writable flag is dropped. A page-address memory that returns junk in any cycle without a read exposes a design that samples the read data one cycle early or one cycle late.

// File: rtl/dmadesc_pkg.sv
// Shared types and constants for the DMA window descriptor builder.
// Assumes 32-bit descriptor words. The page frame field always starts at bit 12.
package dmadesc_pkg;

    localparam logic [1:0] ACC_READ_ONLY = 2'd1;
    localparam logic [1:0] TGT_APERTURE  = 2'd3;
    localparam int         FRAME_LSB     = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR0,
        ST_HDR1,
        ST_LIN_A,
        ST_LIN_B,
        ST_PG_RD,
        ST_PG_WR,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [11:0] cls;
        logic [31:0] eff_off;
        logic [31:0] size;
        logic [1:0]  acc;
        logic [1:0]  tgt;
        logic        sg;
    } win_req_t;

endpackage

// File: rtl/dmadesc_pack.sv
// Header and entry packer: forms both header words, the contiguous-window
// entry and the writable flag from a latched request.
// Assumes the aperture adjustment has already been folded into eff_off.
module dmadesc_pack
    import dmadesc_pkg::*;
(
    input  win_req_t    req,
    output logic [31:0] word0,
    output logic [31:0] word1,
    output logic [31:0] lin_entry,
    output logic        rw_flag
);

    // Pack the descriptor header fields and the single contiguous entry.
    always_comb begin
        rw_flag   = (req.acc != ACC_READ_ONLY);
        word0     = {req.eff_off[11:0], 2'b00, req.tgt, req.acc,
                     ~req.sg, 1'b1, req.cls};
        word1     = req.size - 32'd1;
        lin_entry = {req.eff_off[31:FRAME_LSB], {(FRAME_LSB-2){1'b0}},
                     rw_flag, 1'b0};
    end

endmodule

// File: rtl/dmadesc_span.sv
// Page span calculator: derives the first page index and the rounded-up
// page count of a window, and flags a window that runs past the
// available pages. Uses shifts when PAGE_BYTES is a power of two,
// and a divider otherwise.
module dmadesc_span #(
    parameter int PAGE_BYTES = 4096,
    parameter int PG_AW      = 20,
    parameter int IDX_W      = 21,
    parameter int PCNT_W     = 22
) (
    input  logic [31:0]       eff_off,
    input  logic [31:0]       size,
    input  logic [PG_AW:0]    pages_avail,
    output logic [IDX_W-1:0]  first_idx,
    output logic [PCNT_W-1:0] page_cnt,
    output logic              out_of_range
);

    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam bit IS_POW2    = ((1 << PAGE_SHIFT) == PAGE_BYTES);

    logic [33:0] size_up;
    logic [33:0] span_end;

    assign size_up = {2'b00, size} + 34'(PAGE_BYTES - 1);

    generate
        if (IS_POW2) begin : g_shift
            // Power-of-two pages: index and count by shifting.
            always_comb begin
                first_idx = IDX_W'(eff_off >> PAGE_SHIFT);
                page_cnt  = PCNT_W'(size_up >> PAGE_SHIFT);
            end
        end else begin : g_divide
            // Other page sizes: index and count by division.
            always_comb begin
                first_idx = IDX_W'(eff_off / 32'(PAGE_BYTES));
                page_cnt  = PCNT_W'(size_up / 34'(PAGE_BYTES));
            end
        end
    endgenerate

    // Range test against the number of pages present.
    always_comb begin
        span_end     = 34'(first_idx) + 34'(page_cnt);
        out_of_range = span_end > 34'(pages_avail);
    end

endmodule

// File: rtl/dmadesc_seq.sv
// Write sequencer: steps through the check, the header words and then
// either the two contiguous entries or the per-page fetch/write pairs.
// Assumes the page-address memory returns data one cycle after a read.
module dmadesc_seq
    import dmadesc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PG_AW  = 20,
    parameter int IDX_W  = 21,
    parameter int PCNT_W = 22,
    parameter int WCNT_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sg,
    input  logic              out_of_range,
    input  logic [PCNT_W-1:0] page_cnt,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [ADDR_W-1:0] base,
    input  logic [31:0]       word0,
    input  logic [31:0]       word1,
    input  logic [31:0]       lin_entry,
    input  logic              rw_flag,
    input  logic [31:0]       pg_rd_data,
    output logic              idle,
    output logic              pg_rd_en,
    output logic [PG_AW-1:0]  pg_rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WCNT_W-1:0] words
);

    localparam logic [31:0] FRAME_MASK = ~((32'd1 << FRAME_LSB) - 32'd1);

    seq_state_e        state;
    logic [PCNT_W-1:0] pg_i;
    logic              err_q;
    logic [WCNT_W-1:0] words_q;
    logic [IDX_W:0]    pg_sum;

    // State register and page counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pg_i  <= '0;
            err_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_CHECK;
                    pg_i  <= '0;
                    err_q <= 1'b0;
                end
                ST_CHECK: if (sg && out_of_range) begin
                    err_q <= 1'b1;
                    state <= ST_FIN;
                end else begin
                    state <= ST_HDR0;
                end
                ST_HDR0: state <= ST_HDR1;
                ST_HDR1: begin
                    if (!sg)                 state <= ST_LIN_A;
                    else if (page_cnt == '0) state <= ST_FIN;
                    else                     state <= ST_PG_RD;
                end
                ST_LIN_A: state <= ST_LIN_B;
                ST_LIN_B: state <= ST_FIN;
                ST_PG_RD: state <= ST_PG_WR;
                ST_PG_WR: begin
                    if (pg_i + PCNT_W'(1) == page_cnt) begin
                        state <= ST_FIN;
                    end else begin
                        pg_i  <= pg_i + PCNT_W'(1);
                        state <= ST_PG_RD;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Count the words written in the current build.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
        end else if (state == ST_IDLE && start) begin
            words_q <= '0;
        end else if (wr_en) begin
            words_q <= words_q + WCNT_W'(1);
        end
    end

    assign pg_sum = (IDX_W+1)'(first_idx) + (IDX_W+1)'(pg_i);

    // Drive the write port, the page read port and the status outputs.
    always_comb begin
        wr_en      = 1'b0;
        wr_addr    = base;
        wr_data    = '0;
        pg_rd_en   = 1'b0;
        pg_rd_addr = PG_AW'(pg_sum);
        case (state)
            ST_HDR0: begin
                wr_en   = 1'b1;
                wr_data = word0;
            end
            ST_HDR1: begin
                wr_en   = 1'b1;
                wr_addr = base + ADDR_W'(1);
                wr_data = word1;
            end
            ST_LIN_A: begin
                wr_en   = 1'b1;
                wr_addr = base + ADDR_W'(2);
                wr_data = lin_entry;
            end
            ST_LIN_B: begin
                wr_en   = 1'b1;
                wr_addr = base + ADDR_W'(3);
                wr_data = lin_entry;
            end
            ST_PG_RD: pg_rd_en = 1'b1;
            ST_PG_WR: begin
                wr_en   = 1'b1;
                wr_addr = base + ADDR_W'(2) + ADDR_W'(pg_i);
                wr_data = (pg_rd_data & FRAME_MASK) | {30'd0, rw_flag, 1'b0};
            end
            default: ;
        endcase
        idle  = (state == ST_IDLE);
        busy  = !idle;
        done  = (state == ST_FIN);
        err   = done && err_q;
        words = words_q;
    end

endmodule

// File: rtl/dma_desc_builder.sv
// DMA window descriptor builder top. On start it latches the request,
// folding the host-aperture base into the offset. It then hands the
// request to the packer, the span calculator and the write sequencer.
// Assumes a single write port and a page-address memory with one cycle
// of read latency.
module dma_desc_builder
    import dmadesc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PG_AW      = 20,
    parameter int PAGE_BYTES = 4096,
    parameter int WCNT_W     = 35 - $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [11:0]       obj_class,
    input  logic [31:0]       win_offset,
    input  logic [31:0]       win_size,
    input  logic [1:0]        access_mode,
    input  logic [1:0]        target_sel,
    input  logic              sg_mode,
    input  logic [31:0]       aperture_base,
    input  logic [PG_AW:0]    pages_avail,
    output logic              pg_rd_en,
    output logic [PG_AW-1:0]  pg_rd_addr,
    input  logic [31:0]       pg_rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WCNT_W-1:0] words_written
);

    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam int IDX_W      = 33 - PAGE_SHIFT;
    localparam int PCNT_W     = 34 - PAGE_SHIFT;

    win_req_t          req_q;
    logic [ADDR_W-1:0] base_q;
    logic [PG_AW:0]    avail_q;
    logic              idle;
    logic [31:0]       word0, word1, lin_entry;
    logic              rw_flag;
    logic [IDX_W-1:0]  first_idx;
    logic [PCNT_W-1:0] page_cnt;
    logic              out_of_range;

    // Latch the request while idle, adding the aperture base for target 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            base_q  <= '0;
            avail_q <= '0;
        end else if (idle && start) begin
            req_q.cls     <= obj_class;
            req_q.eff_off <= (target_sel == TGT_APERTURE) ?
                             win_offset + aperture_base : win_offset;
            req_q.size    <= win_size;
            req_q.acc     <= access_mode;
            req_q.tgt     <= target_sel;
            req_q.sg      <= sg_mode;
            base_q        <= desc_base;
            avail_q       <= pages_avail;
        end
    end

    dmadesc_pack u_pack (
        .req       (req_q),
        .word0     (word0),
        .word1     (word1),
        .lin_entry (lin_entry),
        .rw_flag   (rw_flag)
    );

    dmadesc_span #(
        .PAGE_BYTES (PAGE_BYTES),
        .PG_AW      (PG_AW),
        .IDX_W      (IDX_W),
        .PCNT_W     (PCNT_W)
    ) u_span (
        .eff_off      (req_q.eff_off),
        .size         (req_q.size),
        .pages_avail  (avail_q),
        .first_idx    (first_idx),
        .page_cnt     (page_cnt),
        .out_of_range (out_of_range)
    );

    dmadesc_seq #(
        .ADDR_W (ADDR_W),
        .PG_AW  (PG_AW),
        .IDX_W  (IDX_W),
        .PCNT_W (PCNT_W),
        .WCNT_W (WCNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sg           (req_q.sg),
        .out_of_range (out_of_range),
        .page_cnt     (page_cnt),
        .first_idx    (first_idx),
        .base         (base_q),
        .word0        (word0),
        .word1        (word1),
        .lin_entry    (lin_entry),
        .rw_flag      (rw_flag),
        .pg_rd_data   (pg_rd_data),
        .idle         (idle),
        .pg_rd_en     (pg_rd_en),
        .pg_rd_addr   (pg_rd_addr),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .words        (words_written)
    );

endmodule

// File: rtl/dmadesc_chk.sv
// Protocol checker for the descriptor builder, bound to the top module.
// Assumes the top module's port names.
module dmadesc_chk #(
    parameter int WCNT_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              wr_en,
    input logic              pg_rd_en,
    input logic [WCNT_W-1:0] words_written
);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R2
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10
    fetch_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_rd_en |=> (wr_en && !pg_rd_en));

    // R7
    err_no_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (words_written == '0));

    // R3
    write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (busy && !done));

    // R4
    header_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (words_written >= WCNT_W'(2)));

endmodule

bind dma_desc_builder dmadesc_chk #(.WCNT_W(WCNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .wr_en         (wr_en),
    .pg_rd_en      (pg_rd_en),
    .words_written (words_written)
);

// File: tb/dma_desc_builder_test.sv
// Self-checking bench: directed corner cases plus seeded random requests,
// compared with descriptors computed by bench functions.
module dma_desc_builder_test;

    localparam int ADDR_W = 16;
    localparam int PG_AW  = 20;
    localparam int WCNT_W = 23;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] desc_base = '0;
    logic [11:0]       obj_class = '0;
    logic [31:0]       win_offset = '0;
    logic [31:0]       win_size = '0;
    logic [1:0]        access_mode = '0;
    logic [1:0]        target_sel = '0;
    logic              sg_mode = 1'b0;
    logic [31:0]       aperture_base = '0;
    logic [PG_AW:0]    pages_avail = '0;
    logic              pg_rd_en;
    logic [PG_AW-1:0]  pg_rd_addr;
    logic [31:0]       pg_rd_data = '0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              busy, done, err;
    logic [WCNT_W-1:0] words_written;

    int errors = 0;
    int checks = 0;

    logic [ADDR_W-1:0] got_a [0:63];
    logic [31:0]       got_d [0:63];
    int                got_n = 0;
    bit                capture = 1'b0;
    logic [ADDR_W-1:0] exp_a [0:63];
    logic [31:0]       exp_d [0:63];
    int                exp_n;
    bit                exp_err;

    always #10 clk = ~clk;

    dma_desc_builder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_base(desc_base),
        .obj_class(obj_class), .win_offset(win_offset), .win_size(win_size),
        .access_mode(access_mode), .target_sel(target_sel), .sg_mode(sg_mode),
        .aperture_base(aperture_base), .pages_avail(pages_avail),
        .pg_rd_en(pg_rd_en), .pg_rd_addr(pg_rd_addr), .pg_rd_data(pg_rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .done(done), .err(err), .words_written(words_written)
    );

    function automatic logic [31:0] page_word(input logic [PG_AW-1:0] a);
        return ({12'd0, a} * 32'h0001_3579) ^ 32'hC0DE_0FFF;
    endfunction

    // Page-address memory model: one cycle latency, junk when not read.
    always @(posedge clk) begin
        if (pg_rd_en) pg_rd_data <= page_word(pg_rd_addr);
        else          pg_rd_data <= 32'hDEAD_0BAD;
    end

    // Record every write away from the clock edge.
    always @(negedge clk) begin
        if (capture && wr_en && got_n < 64) begin
            got_a[got_n] = wr_addr;
            got_d[got_n] = wr_data;
            got_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build_expect(input [ADDR_W-1:0] b, input [11:0] c,
                                input [31:0] o, input [31:0] s, input [1:0] a,
                                input [1:0] t, input bit g, input [31:0] ab,
                                input [PG_AW:0] av);
        logic [31:0] eff;
        logic [33:0] idx, cnt;
        logic        rw;
        eff = (t == 2'd3) ? o + ab : o;          // R8
        rw  = (a != 2'd1);
        idx = {2'b00, eff} >> 12;
        cnt = ({2'b00, s} + 34'd4095) >> 12;
        exp_err = 1'b0;
        exp_n   = 0;
        if (g && (idx + cnt > {13'd0, av})) begin // R7
            exp_err = 1'b1;
            return;
        end
        exp_a[0] = b;                            // R3
        exp_d[0] = {eff[11:0], 2'b00, t, a, ~g, 1'b1, c};
        exp_a[1] = b + 1;                        // R4
        exp_d[1] = s - 32'd1;
        exp_n = 2;
        if (!g) begin                            // R5
            for (int k = 2; k < 4; k++) begin
                exp_a[k] = b + ADDR_W'(k);
                exp_d[k] = {eff[31:12], 10'd0, rw, 1'b0};
            end
            exp_n = 4;
        end else begin                           // R6
            for (int k = 0; k < int'(cnt); k++) begin
                exp_a[k+2] = b + ADDR_W'(k + 2);
                exp_d[k+2] = (page_word(PG_AW'(idx + 34'(k))) & 32'hFFFF_F000) |
                             {30'd0, rw, 1'b0};
            end
            exp_n = 2 + int'(cnt);
        end
    endtask

    task automatic run_case(input [ADDR_W-1:0] b, input [11:0] c,
                            input [31:0] o, input [31:0] s, input [1:0] a,
                            input [1:0] t, input bit g, input [31:0] ab,
                            input [PG_AW:0] av, input bit poke);
        int n;
        build_expect(b, c, o, s, a, t, g, ab, av);
        @(negedge clk);
        desc_base = b; obj_class = c; win_offset = o; win_size = s;
        access_mode = a; target_sel = t; sg_mode = g; aperture_base = ab;
        pages_avail = av; got_n = 0; capture = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", 32'(busy), 32'd1);
        if (poke) begin
            // R2: a second start while busy must not disturb the build
            obj_class = ~c; win_offset = ~o; desc_base = ~b; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (done !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) begin
            check(1'b0, "R9 watchdog: done never seen", 32'(n), 32'd0);
        end else begin
            check(err === exp_err, "R7 error flag", 32'(err), 32'(exp_err));
            check(words_written === WCNT_W'(exp_n), "R9 word count",
                  32'(words_written), 32'(exp_n));
            check(got_n == exp_n, "R5/R6 number of writes", 32'(got_n), 32'(exp_n));
            for (int k = 0; k < exp_n && k < got_n; k++) begin
                check(got_a[k] === exp_a[k], "R3/R6 write address",
                      32'(got_a[k]), 32'(exp_a[k]));
                check(got_d[k] === exp_d[k], "R3/R4/R5/R6 write data",
                      got_d[k], exp_d[k]);
            end
        end
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R9 single done then idle",
              {30'd0, done, busy}, 32'd0);
        capture = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0 && pg_rd_en === 1'b0,
              "R1 reset state", {28'd0, busy, done, wr_en, pg_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0 && pg_rd_en === 1'b0,
              "R1 after reset", {28'd0, busy, done, wr_en, pg_rd_en}, 32'd0);

        // R5 contiguous, read/write, plain target
        run_case(16'h0100, 12'h03D, 32'h1234_5678, 32'h0000_8000, 2'd0, 2'd0, 1'b0, 32'h0, 21'd0, 1'b0);
        // R5 read-only drops bit 1
        run_case(16'h0200, 12'hFFF, 32'hABCD_EFFF, 32'h0000_0010, 2'd1, 2'd2, 1'b0, 32'h0, 21'd0, 1'b0);
        // R8 aperture add with wrap past 2^32
        run_case(16'h0300, 12'h002, 32'hFFFF_F123, 32'h0000_1000, 2'd2, 2'd3, 1'b0, 32'h0000_2000, 21'd0, 1'b0);
        // R4 size zero gives all-ones limit
        run_case(16'h0400, 12'h010, 32'h0000_5000, 32'h0, 2'd0, 2'd1, 1'b0, 32'h0, 21'd0, 1'b0);
        // R6 page-listed, size zero: header only
        run_case(16'h0500, 12'h011, 32'h0000_3000, 32'h0, 2'd0, 2'd2, 1'b1, 32'h0, 21'd10, 1'b0);
        // R6 exactly one page, then one byte over
        run_case(16'h0600, 12'h012, 32'h0000_2345, 32'h0000_1000, 2'd0, 2'd2, 1'b1, 32'h0, 21'd10, 1'b0);
        run_case(16'h0700, 12'h013, 32'h0000_2345, 32'h0000_1001, 2'd1, 2'd2, 1'b1, 32'h0, 21'd10, 1'b0);
        // R7 boundary: ends on last page accepted, one further rejected
        run_case(16'h0800, 12'h014, 32'h0000_7000, 32'h0000_3000, 2'd0, 2'd2, 1'b1, 32'h0, 21'd10, 1'b0);
        run_case(16'h0900, 12'h015, 32'h0000_7000, 32'h0000_3001, 2'd0, 2'd2, 1'b1, 32'h0, 21'd10, 1'b0);
        // R8 aperture shifts the page index of a page-listed window
        run_case(16'h0A00, 12'h016, 32'h0000_1000, 32'h0000_2000, 2'd2, 2'd3, 1'b1, 32'h0000_4000, 21'd8, 1'b0);
        // R2 start while busy ignored, both layouts
        run_case(16'h0B00, 12'h017, 32'h0000_2000, 32'h0000_3000, 2'd0, 2'd0, 1'b1, 32'h0, 21'd20, 1'b1);
        run_case(16'h0C00, 12'h018, 32'h5555_A000, 32'h0000_0100, 2'd0, 2'd0, 1'b0, 32'h0, 21'd0, 1'b1);
        // R6 descriptor address wraps at the top of instance memory
        run_case(16'hFFFE, 12'h019, 32'h0000_0000, 32'h0000_2000, 2'd0, 2'd0, 1'b1, 32'h0, 21'd4, 1'b0);

        // Seeded random requests
        for (int i = 0; i < 60; i++) begin
            bit          g;
            logic [1:0]  t, a;
            logic [31:0] o, s, ab;
            g  = 1'($urandom % 2);
            t  = 2'($urandom % 4);
            a  = 2'($urandom % 3);
            s  = g ? ($urandom % (8 * 4096 + 1)) : $urandom;
            o  = g ? ($urandom % (80 * 4096)) : $urandom;
            ab = g ? ($urandom % (4 * 4096)) : $urandom;
            run_case(16'($urandom), 12'($urandom), o, s, a, t, g, ab,
                     21'(40 + $urandom % 40), 1'($urandom % 4 == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule